// File: doc/BRIEF.md
# Receive-Error Interrupt Controller

This block gathers single-cycle error pulses from a cell receive datapath into a set of sticky status flags and raises one active-low interrupt line when a flag that is currently allowed to signal is set. Software configures it through a byte-wide register port. A control byte at address 0x00 holds two bits that matter. Bit 0 is a global enable. Bit 5 is an error-only mode that lets only the three cell-error sources reach the interrupt line.

The status flags live at address 0x01. The three cell-error sources sit in bits 0 to 2: bad header check (bit 0), short cell of fewer than 53 bytes (bit 1) and symbol error (bit 2). Other sources, such as FIFO overflow in bit 3, take the higher bits. A read of 0x01 returns the flags and clears them all in the same cycle, which releases the interrupt line. Masking never stops a flag from being recorded. It only gates the interrupt output.

The register port returns read data one cycle after the read strobe.

Top module: `rx_err_irq`

## Requirements
- R1: After reset the control byte and all status flags are 0, `irqN` is 1 and `regRdData` is 0.
- R2: A 1 on `evtPulse[i]` at a clock edge sets status flag i. The flag stays set until a status read clears it, whatever the control byte holds.
- R3: While control bit 0 is 0, `irqN` stays 1 whatever flags are set.
- R4: With control bit 0 = 1 and bit 5 = 0, `irqN` is 0 exactly when at least one status flag is set.
- R5: With control bit 0 = 1 and bit 5 = 1, `irqN` is 0 exactly when at least one of status flags 0 to 2 is set. Flags 3 and up have no effect on `irqN`.
- R6: A read (`regRdEn` = 1) at address 0x01 puts the flags as they stood before the edge into `regRdData` bits NUM_SRC-1:0 in the next cycle, with the upper bits 0. The same edge clears every flag, so `irqN` returns to 1.
- R7: An event pulse that arrives at the same edge as a clearing status read leaves its flag set after that edge.
- R8: A write (`regWrEn` = 1) at address 0x00 stores `regWrData` as the control byte. A later read at 0x00 returns that byte in the next cycle.
- R9: A read at any address other than 0x00 or 0x01 returns 0 and leaves the flags unchanged. Writes to any address other than 0x00, including 0x01, change neither the flags nor the control byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| evtPulse | input | NUM_SRC | Error event pulses, one bit per source |
| regAddr | input | ADDR_W | Register address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | DATA_W | Write data |
| regRdEn | input | 1 | Read strobe |
| regRdData | output | DATA_W | Read data, valid the cycle after the strobe |
| irqN | output | 1 | Active-low interrupt |

## Verification
A wrong flag or a wrong mask bit shows on `irqN` in the cycle right after the event edge. The same fault shows on `regRdData` one cycle after the next status read. A failed clear shows as a nonzero value on a second status read that comes straight after the first. The bench sweeps every event pattern of a five-source configuration under all four settings of the enable and error-only bits. For each case it checks the interrupt level, the read-back value and the release of the line.

// File: rtl/rx_err_irq_pkg.sv
package rx_err_irq_pkg;
  localparam int CTRL_ADDR   = 0;
  localparam int STAT_ADDR   = 1;
  localparam int EN_BIT      = 0;
  localparam int ERRONLY_BIT = 5;
  localparam int CELL_ERR_W  = 3;

  typedef struct packed {
    logic clearStatus;
    logic readCtrl;
    logic readStatus;
    logic readOther;
  } regStrobe_t;
endpackage

// File: rtl/rx_err_irq_ctrl.sv
module rx_err_irq_ctrl
  import rx_err_irq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  input  logic              regRdEn,
  output logic [DATA_W-1:0] ctrlByte,
  output regStrobe_t        strobe
);
  logic hitCtrl;
  logic hitStat;

  assign hitCtrl = (regAddr == ADDR_W'(CTRL_ADDR));
  assign hitStat = (regAddr == ADDR_W'(STAT_ADDR));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlByte <= '0;
    else if (regWrEn && hitCtrl) ctrlByte <= regWrData;
  end

  always_comb begin
    strobe.clearStatus = regRdEn && hitStat;
    strobe.readStatus  = regRdEn && hitStat;
    strobe.readCtrl    = regRdEn && hitCtrl;
    strobe.readOther   = regRdEn && !hitCtrl && !hitStat;
  end

  // R8/R9: control byte only moves on a write to its own address
  p_ctrl_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && hitCtrl) |=> $stable(ctrlByte));

  // read strobes are mutually exclusive
  p_one_sel_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.readCtrl, strobe.readStatus, strobe.readOther}));
endmodule

// File: rtl/rx_err_irq_dp.sv
module rx_err_irq_dp
  import rx_err_irq_pkg::*;
#(
  parameter int NUM_SRC = 5,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic [DATA_W-1:0]  ctrlByte,
  input  regStrobe_t         strobe,
  output logic [DATA_W-1:0]  regRdData,
  output logic               irqN
);
  logic [NUM_SRC-1:0] statusReg;
  logic [NUM_SRC-1:0] srcMask;
  logic               gEnable;
  logic               errOnly;

  assign gEnable = ctrlByte[EN_BIT];
  assign errOnly = ctrlByte[ERRONLY_BIT];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) statusReg[i] <= 1'b0;
      else       statusReg[i] <= (statusReg[i] && !strobe.clearStatus) || evtPulse[i];
    end
    if (i < CELL_ERR_W) begin : g_cell
      assign srcMask[i] = gEnable;
    end else begin : g_other
      assign srcMask[i] = gEnable && !errOnly;
    end
  end

  assign irqN = !(|(statusReg & srcMask));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regRdData <= '0;
    else if (strobe.readCtrl)   regRdData <= ctrlByte;
    else if (strobe.readStatus) regRdData <= DATA_W'(statusReg);
    else if (strobe.readOther)  regRdData <= '0;
  end

  // R2: an event always lands in its flag
  p_evt_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    (|evtPulse) |=> ((statusReg & $past(evtPulse)) == $past(evtPulse)));

  // R2: without a clearing read no flag falls
  p_sticky_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clearStatus |=> ((statusReg & $past(statusReg)) == $past(statusReg)));

  // R3: disabled means no interrupt
  p_irq_off_r3: assert property (@(posedge clk) disable iff (!rstN)
    !gEnable |-> irqN);

  // R5: in error-only mode the cell flags alone drive the line
  p_erronly_r5: assert property (@(posedge clk) disable iff (!rstN)
    (gEnable && errOnly) |-> (irqN == !(|statusReg[CELL_ERR_W-1:0])));

  // R6/R7: after a clear only same-edge events remain
  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearStatus |=> (statusReg == $past(evtPulse)));

  // R9: reads of unmapped addresses return zero
  p_rd_other_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.readOther |=> (regRdData == '0));
endmodule

// File: rtl/rx_err_irq.sv
module rx_err_irq
  import rx_err_irq_pkg::*;
#(
  parameter int NUM_SRC = 5,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic               regRdEn,
  output logic [DATA_W-1:0]  regRdData,
  output logic               irqN
);
  regStrobe_t        strobe;
  logic [DATA_W-1:0] ctrlByte;

  rx_err_irq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdEn(regRdEn), .ctrlByte(ctrlByte),
    .strobe(strobe)
  );

  rx_err_irq_dp #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .ctrlByte(ctrlByte),
    .strobe(strobe), .regRdData(regRdData), .irqN(irqN)
  );
endmodule

// File: tb/sim_rx_err_irq.sv
`timescale 1ns/1ps
module sim_rx_err_irq;
  localparam int NS = 5;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] evtPulse = '0;
  logic [7:0]    regAddr = '0;
  logic          regWrEn = 1'b0;
  logic [7:0]    regWrData = '0;
  logic          regRdEn = 1'b0;
  logic [7:0]    regRdData;
  logic          irqN;

  int nChecks = 0;
  int nFail = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  rx_err_irq #(.NUM_SRC(NS), .ADDR_W(8), .DATA_W(8)) u0 (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdEn(regRdEn),
    .regRdData(regRdData), .irqN(irqN)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [7:0] a, input logic [NS-1:0] evt, output logic [7:0] v);
    @(negedge clk); regAddr = a; regRdEn = 1'b1; evtPulse = evt;
    @(negedge clk); regRdEn = 1'b0; evtPulse = '0; v = regRdData;
  endtask

  task automatic pulse(input logic [NS-1:0] p);
    @(negedge clk); evtPulse = p;
    @(negedge clk); evtPulse = '0;
  endtask

  initial begin
    #400000;
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(irqN == 1'b1, "R1 irqN in reset", irqN, 1);
    rstN = 1'b1;
    @(negedge clk);
    check(irqN == 1'b1 && regRdData == 8'h00, "R1 outputs after reset", {irqN, regRdData}, 9'h100);
    rdReg(8'h00, '0, rv); check(rv == 8'h00, "R1 ctrl reset", rv, 0);
    rdReg(8'h01, '0, rv); check(rv == 8'h00, "R1 status reset", rv, 0);

    // R8: control byte readback
    for (int k = 0; k < 8; k++) begin
      logic [7:0] d;
      d = 8'(1 << k) ^ 8'h5A;
      wrReg(8'h00, d);
      rdReg(8'h00, '0, rv); check(rv == d, "R8 ctrl readback", rv, d);
    end

    // R2..R6 sweep over control modes and all event patterns
    for (int m = 0; m < 4; m++) begin
      logic en, eo;
      en = m[0]; eo = m[1];
      wrReg(8'h00, {2'b00, eo, 4'b0000, en});
      for (int p = 0; p < (1 << NS); p++) begin
        logic expIrq;
        logic [NS-1:0] pv;
        pv = NS'(p);
        expIrq = en && (eo ? (|pv[2:0]) : (|pv));
        pulse(pv);
        check(irqN == !expIrq, en ? (eo ? "R5 error-only irq" : "R4 all-source irq") : "R3 disabled irq",
              irqN, !expIrq);
        pulse('0);
        check(irqN == !expIrq, "R2 sticky irq level", irqN, !expIrq);
        rdReg(8'h01, '0, rv);
        check(rv == 8'(pv), "R2 status readback", rv, pv);
        check(irqN == 1'b1, "R6 irq released after read", irqN, 1);
        rdReg(8'h01, '0, rv);
        check(rv == 8'h00, "R6 status cleared", rv, 0);
      end
    end

    // R7: event at the same edge as the clearing read
    wrReg(8'h00, 8'h01);
    pulse(5'b00001);
    rdReg(8'h01, 5'b00010, rv);
    check(rv == 8'h01, "R7 read value before edge", rv, 1);
    check(irqN == 1'b0, "R7 irq kept by new event", irqN, 0);
    rdReg(8'h01, '0, rv);
    check(rv == 8'h02, "R7 event kept", rv, 2);

    // R9: unmapped reads and writes
    pulse(5'b10101);
    rdReg(8'h05, '0, rv); check(rv == 8'h00, "R9 unmapped read zero", rv, 0);
    check(irqN == 1'b0, "R9 unmapped read keeps irq", irqN, 0);
    wrReg(8'h01, 8'h00);
    wrReg(8'h07, 8'hFF);
    rdReg(8'h00, '0, rv); check(rv == 8'h01, "R9 ctrl untouched", rv, 1);
    rdReg(8'h01, '0, rv); check(rv == 8'h15, "R9 status untouched", rv, 8'h15);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule